// File: doc/BRIEF.md
# Compare Channel Output Reference Generator

This block forms the output reference level of one compare channel of a general-purpose timer. It takes the running counter value and the count direction from the counter, along with strobes for update events, for overflow or underflow, and for triggers. It keeps an active compare value and a second, alternate compare value. Each of the two can be written either straight into its active copy or through a preload buffer that moves into the active copy on an update event. From these inputs it detects counter matches and produces the reference level. The level follows a 4-bit output mode: hold, set, clear or toggle on a match, force to a level, two symmetric PWM modes, and two asymmetric PWM modes.

Asymmetric PWM compares against the main value while the counter counts up and against the alternate value while it counts down. This lets a center-aligned waveform have edges that are not mirror images. A trigger can force the reference to its active level at once in the symmetric PWM modes when immediate-active is enabled. The forced level lasts until the next overflow or underflow. The block also produces a DMA request, taken either from the compare match or from the update event. Polarity, dead time, pin enables and the counter itself belong to neighbouring blocks.

Top module: `cmp_oref_gen`

## Requirements
- R1: Mode code 0000 holds the reference level. Unlisted codes 1000 to 1101 also hold it.
- R2: On a cycle where the counter equals the active main compare value, mode 0001 drives the level to 0, mode 0010 drives it to 1, and mode 0011 inverts it. With no match the level is held.
- R3: Mode 0100 drives the level to 0 and mode 0101 drives it to 1, whatever the counter and compare values are.
- R4: In mode 0110 (PWM type 1), the level is 1 while counting up with counter < main compare. While counting down, the level is 1 unless counter > main compare.
- R5: Mode 0111 (PWM type 2) gives the inverse of mode 0110 in both directions.
- R6: Modes 1110 and 1111 behave as 0110 and 0111 when counting up. When counting down, they compare against the alternate value instead of the main value.
- R7: With preload off, a write reaches the active compare value at the next clock edge. With preload on, the write waits in a buffer and moves to the active value on the edge where an update event is seen.
- R8: In mode 0110 or 0111 with immediate-active enabled, a trigger makes the level 1 from the next edge on. It stays 1 until an overflow/underflow strobe ends the forcing, after which the normal PWM level resumes.
- R9: Immediate-active and triggers have no effect in any mode other than 0110 and 0111.
- R10: The match output is 1 in exactly those cycles in which the counter input equals the active main compare value.
- R11: With the DMA select at 0, the DMA request follows the match output. With the select at 1, it follows the update strobe.
- R12: After reset, the level is 0 and both compare values are 0.
- R13: The reference level is registered: it reflects the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Running counter value |
| cnt_down_i | input | 1 | 1 while the counter counts down |
| upd_evt_i | input | 1 | Update event strobe |
| ovf_evt_i | input | 1 | Overflow or underflow strobe |
| trig_evt_i | input | 1 | Trigger event strobe |
| wr_main_i | input | 1 | Write strobe for the main compare value |
| wr_alt_i | input | 1 | Write strobe for the alternate compare value |
| wr_data_i | input | CNT_W | Compare write data |
| mode_i | input | 4 | Output mode code |
| preload_en_i | input | 1 | Route writes through the preload buffer |
| imm_act_en_i | input | 1 | Enable trigger-forced active level |
| dma_sel_i | input | 1 | DMA request source: 0 match, 1 update |
| oref_o | output | 1 | Output reference level |
| match_o | output | 1 | Counter equals active main compare value |
| dma_req_o | output | 1 | DMA request |

## Verification
Embedded properties watch every cycle for the mode effects that need no arithmetic. They check the forced levels, the held level in mode 0000, and the forced-active level after a qualifying trigger. They also check the direct-write and preload-wait behaviour of both compare registers. Behaviours that depend on comparisons can only be shown by the bench's scenarios against its reference model. These are the PWM and asymmetric levels in each direction, toggling on a match, and the end of forcing at an overflow. The same applies to a preload buffer that is released by an update while other writes go on, and to the DMA source selection.

// File: rtl/cmp_oref_pkg.sv
package cmp_oref_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        OM_HOLD  = 4'b0000,
        OM_CLR   = 4'b0001,
        OM_SET   = 4'b0010,
        OM_TOG   = 4'b0011,
        OM_FLO   = 4'b0100,
        OM_FHI   = 4'b0101,
        OM_PWM1  = 4'b0110,
        OM_PWM2  = 4'b0111,
        OM_APWM1 = 4'b1110,
        OM_APWM2 = 4'b1111
    } omode_e;

    typedef struct packed {
        logic oref;
        logic imm;
    } oref_st_t;

endpackage

// File: rtl/cmp_value_reg.sv
module cmp_value_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         preload_i,
    input  logic         upd_i,
    output logic [W-1:0] active_o
);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.pend = data_i;
        if (!preload_i) begin
            if (wr_i) st_d.act = data_i;
        end else if (upd_i) begin
            st_d.act = st_d.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.act;

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !preload_i) |=> (active_o == $past(data_i))); // R7
    AST_PRELOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_i && !upd_i) |=> $stable(active_o)); // R7

endmodule

// File: rtl/cmp_oref_logic.sv
module cmp_oref_logic
    import cmp_oref_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      cnt_i,
    input  logic              down_i,
    input  logic [W-1:0]      cmp_main_i,
    input  logic [W-1:0]      cmp_alt_i,
    input  logic              ovf_i,
    input  logic              trig_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              imm_en_i,
    output logic              oref_o,
    output logic              match_o
);

    oref_st_t st_d, st_q;
    logic [W-1:0] pwm_cmp;
    logic hit, asym, pwm12, pwm_lvl, force_now;

    always_comb begin
        st_d      = st_q;
        hit       = (cnt_i == cmp_main_i);
        asym      = (mode_i == OM_APWM1) || (mode_i == OM_APWM2);
        pwm12     = (mode_i == OM_PWM1) || (mode_i == OM_PWM2);
        pwm_cmp   = (asym && down_i) ? cmp_alt_i : cmp_main_i;
        pwm_lvl   = down_i ? !(cnt_i > pwm_cmp) : (cnt_i < pwm_cmp);
        force_now = pwm12 && imm_en_i && (trig_i || (st_q.imm && !ovf_i));
        st_d.imm  = force_now;
        case (mode_i)
            OM_CLR:   if (hit) st_d.oref = 1'b0;
            OM_SET:   if (hit) st_d.oref = 1'b1;
            OM_TOG:   if (hit) st_d.oref = !st_q.oref;
            OM_FLO:   st_d.oref = 1'b0;
            OM_FHI:   st_d.oref = 1'b1;
            OM_PWM1,
            OM_APWM1: st_d.oref = pwm_lvl;
            OM_PWM2,
            OM_APWM2: st_d.oref = !pwm_lvl;
            default:  st_d.oref = st_q.oref;
        endcase
        if (force_now) st_d.oref = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oref_o  = st_q.oref;
    assign match_o = hit;

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OM_FLO) |=> !oref_o); // R3
    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OM_FHI) |=> oref_o); // R3
    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OM_HOLD) |=> $stable(oref_o)); // R1
    AST_IMM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm12 && imm_en_i && trig_i) |=> oref_o); // R8

endmodule

// File: rtl/cmp_oref_gen.sv
module cmp_oref_gen
    import cmp_oref_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic             upd_evt_i,
    input  logic             ovf_evt_i,
    input  logic             trig_evt_i,
    input  logic             wr_main_i,
    input  logic             wr_alt_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [3:0]       mode_i,
    input  logic             preload_en_i,
    input  logic             imm_act_en_i,
    input  logic             dma_sel_i,
    output logic             oref_o,
    output logic             match_o,
    output logic             dma_req_o
);

    localparam int N_CMP = 2;

    logic [N_CMP-1:0]            wr_vec;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_val;

    assign wr_vec = {wr_alt_i, wr_main_i};

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        cmp_value_reg #(.W(CNT_W)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_vec[g]),
            .data_i    (wr_data_i),
            .preload_i (preload_en_i),
            .upd_i     (upd_evt_i),
            .active_o  (cmp_val[g])
        );
    end

    cmp_oref_logic #(.W(CNT_W)) u_logic (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt_i),
        .down_i     (cnt_down_i),
        .cmp_main_i (cmp_val[0]),
        .cmp_alt_i  (cmp_val[1]),
        .ovf_i      (ovf_evt_i),
        .trig_i     (trig_evt_i),
        .mode_i     (mode_i),
        .imm_en_i   (imm_act_en_i),
        .oref_o     (oref_o),
        .match_o    (match_o)
    );

    assign dma_req_o = dma_sel_i ? upd_evt_i : match_o;

endmodule

// File: tb/cmp_oref_gen_tb_top.sv
module cmp_oref_gen_tb_top;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] cnt_i = '0;
    logic cnt_down_i = 1'b0, upd_evt_i = 1'b0, ovf_evt_i = 1'b0, trig_evt_i = 1'b0;
    logic wr_main_i = 1'b0, wr_alt_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic [3:0] mode_i = 4'b0000;
    logic preload_en_i = 1'b0, imm_act_en_i = 1'b0, dma_sel_i = 1'b0;
    logic oref_o, match_o, dma_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] m_main = '0, m_alt = '0, m_pmain = '0, m_palt = '0;
    logic m_oref = 1'b0, m_imm = 1'b0;

    always #5 clk = ~clk;

    cmp_oref_gen #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i),
        .upd_evt_i(upd_evt_i), .ovf_evt_i(ovf_evt_i), .trig_evt_i(trig_evt_i),
        .wr_main_i(wr_main_i), .wr_alt_i(wr_alt_i), .wr_data_i(wr_data_i),
        .mode_i(mode_i), .preload_en_i(preload_en_i), .imm_act_en_i(imm_act_en_i),
        .dma_sel_i(dma_sel_i), .oref_o(oref_o), .match_o(match_o), .dma_req_o(dma_req_o)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string mode_req(logic [3:0] m);
        case (m)
            4'b0001, 4'b0010, 4'b0011: return "R2";
            4'b0100, 4'b0101:          return "R3";
            4'b0110:                   return "R4";
            4'b0111:                   return "R5";
            4'b1110, 4'b1111:          return "R6";
            default:                   return "R1";
        endcase
    endfunction

    function automatic logic pwm_ref(logic [W-1:0] c, logic dn, logic [W-1:0] cmp);
        return dn ? !(c > cmp) : (c < cmp);
    endfunction

    // inputs already driven after a falling edge; checks R10/R11, then R13 at the edge
    task automatic cycle(string tag);
        logic [W-1:0] n_pm, n_pa, n_m, n_a, pc;
        logic n_o, n_i, hit, pwm12, asym, lv;
        string t;
        #1;
        hit = (cnt_i == m_main);
        chk("R10", match_o, hit);
        chk("R11", dma_req_o, dma_sel_i ? upd_evt_i : hit);
        n_pm = wr_main_i ? wr_data_i : m_pmain;
        n_pa = wr_alt_i ? wr_data_i : m_palt;
        n_m = m_main; n_a = m_alt;
        if (!preload_en_i) begin
            if (wr_main_i) n_m = wr_data_i;
            if (wr_alt_i)  n_a = wr_data_i;
        end else if (upd_evt_i) begin
            n_m = n_pm; n_a = n_pa;
        end
        pwm12 = (mode_i == 4'b0110) || (mode_i == 4'b0111);
        asym  = (mode_i == 4'b1110) || (mode_i == 4'b1111);
        pc = (asym && cnt_down_i) ? m_alt : m_main;
        lv = pwm_ref(cnt_i, cnt_down_i, pc);
        n_o = m_oref;
        case (mode_i)
            4'b0001: if (hit) n_o = 1'b0;
            4'b0010: if (hit) n_o = 1'b1;
            4'b0011: if (hit) n_o = !m_oref;
            4'b0100: n_o = 1'b0;
            4'b0101: n_o = 1'b1;
            4'b0110, 4'b1110: n_o = lv;
            4'b0111, 4'b1111: n_o = !lv;
            default: ;
        endcase
        n_i = pwm12 && imm_act_en_i && (trig_evt_i || (m_imm && !ovf_evt_i));
        if (n_i) n_o = 1'b1;
        t = (tag == "") ? mode_req(mode_i) : tag;
        @(posedge clk);
        #1;
        m_pmain = n_pm; m_palt = n_pa; m_main = n_m; m_alt = n_a;
        m_oref = n_o; m_imm = n_i;
        chk(t, oref_o, m_oref);
        @(negedge clk);
    endtask

    task automatic quiet();
        upd_evt_i = 0; ovf_evt_i = 0; trig_evt_i = 0; wr_main_i = 0; wr_alt_i = 0;
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12", oref_o, 1'b0);
        chk("R12", match_o, 1'b1);   // counter 0 equals reset compare 0
        @(negedge clk);

        // R7 preload: write waits for update
        preload_en_i = 1; wr_main_i = 1; wr_data_i = 16'd5; cycle("R7");
        quiet(); cnt_i = 16'd5; cycle("R7");
        chk("R7", match_o, 1'b0);
        upd_evt_i = 1; cycle("R7");
        quiet(); #1; chk("R7", match_o, 1'b1);
        cycle("R7");
        // R7 direct write
        preload_en_i = 0; wr_main_i = 1; wr_data_i = 16'd9; cycle("R7");
        quiet(); cnt_i = 16'd9; #1; chk("R7", match_o, 1'b1);
        cycle("R7");

        // R8 immediate active in PWM type 1, counter above compare -> normally 0
        mode_i = 4'b0110; imm_act_en_i = 1; cnt_i = 16'd12; cnt_down_i = 0;
        cycle("R4");
        chk("R4", oref_o, 1'b0);
        trig_evt_i = 1; cycle("R8");
        chk("R8", oref_o, 1'b1);
        quiet(); repeat (4) cycle("R8");
        chk("R8", oref_o, 1'b1);
        ovf_evt_i = 1; cycle("R8");
        quiet(); cycle("R8");
        chk("R8", oref_o, 1'b0);

        // R9 trigger ignored outside PWM 1/2
        mode_i = 4'b0100; cycle("R9");
        trig_evt_i = 1; cycle("R9");
        chk("R9", oref_o, 1'b0);
        quiet(); mode_i = 4'b1110; cnt_i = 16'd12; trig_evt_i = 1; cycle("R9");
        chk("R9", oref_o, 1'b0);
        quiet();

        // R6 asymmetric: alternate compare on down-count
        mode_i = 4'b0100; wr_alt_i = 1; wr_data_i = 16'd3; cycle("R6");
        quiet(); mode_i = 4'b1110; cnt_down_i = 1; cnt_i = 16'd5; cycle("R6");
        chk("R6", oref_o, 1'b0);     // 5 > 3 -> inactive, main 9 would give 1
        cnt_down_i = 0; cycle("R6");
        chk("R6", oref_o, 1'b1);     // 5 < 9

        // random mix
        for (int seg = 0; seg < 150; seg++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 15));
            mode_i = m;
            imm_act_en_i = 1'($urandom_range(0, 1));
            preload_en_i = 1'($urandom_range(0, 1));
            dma_sel_i = 1'($urandom_range(0, 1));
            for (int k = 0; k < 20; k++) begin
                cnt_i      = 16'($urandom_range(0, 15));
                cnt_down_i = 1'($urandom_range(0, 1));
                upd_evt_i  = ($urandom_range(0, 7) == 0);
                ovf_evt_i  = ($urandom_range(0, 9) == 0);
                trig_evt_i = ($urandom_range(0, 9) == 0);
                wr_main_i  = ($urandom_range(0, 5) == 0);
                wr_alt_i   = ($urandom_range(0, 5) == 0);
                wr_data_i  = 16'($urandom_range(0, 15));
                cycle("");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule